// File: doc/BRIEF.md
# Dual-Channel Multi-Mode Timer

This block is a peripheral timer with two independent channels. Each channel holds a down-counter, a clock prescaler and a reload value, and runs in one of three behaviours: periodic (it reloads on every expiry), one-shot (it stops after the first expiry) or watchdog (software must keep servicing it, or a reset request is raised). Software can change the behaviour of a channel at run time through its control field.

Software reaches the block through a plain single-cycle register port. A write takes effect on the clock edge where `wr_en_i` is high. A read is combinational from `addr_i`. The low three address bits pick a register and the bits above them pick the channel. The port has no handshake: the block accepts every write in the cycle it is presented, so there is no back-pressure. Each channel drives its own interrupt line. All channels share one watchdog reset request output.

Top module: `duo_timer`

## Requirements
- R1: After reset every register of every channel reads zero, every interrupt output is low and the watchdog reset request is low.
- R2: `addr_i[2:0]` selects the register and `addr_i[AW-1:3]` selects the channel. The register offsets are:
  - 0: control. bit0 = enable, bits2:1 = mode (01 one-shot, 10 watchdog, any other value periodic), bit3 = interrupt enable.
  - 1: reload value.
  - 2: prescale value.
  - 3: count. Read only.
  - 4: status. bit0 = pending, write 1 to clear. bit1 = running. bit2 = watchdog expired.
  - 5: service.
  - Control, reload and prescale read back the last value written.
- R3: A write that turns the enable bit on loads the count with the reload value R. While the channel is enabled, the count decreases by one every P+1 cycles, where P is the prescale value. The step that finds the count at zero is an expiry. After m edges, the count reads R - (floor(m/(P+1)) mod (R+1)) in periodic mode.
- R4: In periodic mode an expiry sets pending, reloads the count from the reload register and keeps the channel running.
- R5: In one-shot mode an expiry sets pending, clears the enable bit and leaves the count at zero. The count then stays at zero, and no further expiry occurs until software re-enables the channel.
- R6: In watchdog mode, writing the key 32'hC0DE_5A5A to the service register reloads both the count and the prescaler. Writing any other value to the service register changes nothing. An expiry sets pending and the watchdog-expired bit, stops the channel, and raises `wdog_rst_o`, which stays high until reset.
- R7: A pending bit stays set until software writes 1 to status bit0. Writing 0 to that bit has no effect. If an expiry and a clear fall in the same cycle, the bit stays set. The channel's `irq_o` bit equals its pending bit ANDed with its interrupt enable bit.
- R8: A reload or prescale value written while the channel runs does not change the current count or tick rate. It takes effect at the next reload: a periodic expiry, a watchdog service or an enable.
- R9: The channels count independently. Writes to one channel never alter another channel.
- R10: Clearing the enable bit freezes the count. Enabling again restarts the count from the reload value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW (4) | Channel and register select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| irq_o | output | NCH (2) | Per-channel interrupt request |
| wdog_rst_o | output | 1 | Sticky watchdog reset request |

## Verification
Random pairs of reload and prescale values are run on both channels at once. One channel is always periodic and the other is randomly periodic or one-shot. These runs separate a wrong tick rate, an off-by-one at the zero crossing and leakage between channels, because each count is compared to a closed-form expected value. Directed sequences then cover three things:
- a reload or prescale write in mid-run, which separates "next reload" behaviour from an immediate update;
- correct and wrong watchdog keys, which separate a real service from any write to the service register;
- a clear that lands on an expiry cycle, which separates set-wins priority from clear-wins priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW = 32;

  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_RELOAD = 3'd1,
    REG_PRESC  = 3'd2,
    REG_COUNT  = 3'd3,
    REG_STAT   = 3'd4,
    REG_SVC    = 3'd5
  } reg_e;

  typedef enum logic [1:0] {
    MODE_PERIODIC = 2'b00,
    MODE_ONESHOT  = 2'b01,
    MODE_WDOG     = 2'b10,
    MODE_ALT      = 2'b11
  } mode_e;

  typedef struct packed {
    logic  ie;
    mode_e mode;
    logic  en;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [PRE_W-1:0] load_val_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (run_i) begin
      if (cnt_q == '0) cnt_q <= div_i;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int          CNT_W = 32,
  parameter int          PRE_W = 32,
  parameter logic [31:0] KEY   = 32'hC0DE_5A5A
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  reg_e             reg_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             pend_o,
  output logic             run_o,
  output logic             irq_o,
  output logic             bite_o
);
  ctrl_t            ctrl_q, ctrl_new;
  logic [CNT_W-1:0] rl_q, cnt_q;
  logic [PRE_W-1:0] ps_q, act_ps_q;
  logic             pend_q, bite_q;
  logic             is_wd, is_os, is_per;
  logic             wr_ctrl, start, svc, tick, expire, reload, clr;

  always_comb begin
    ctrl_new = ctrl_t'(wdata_i[3:0]);
    is_wd    = (ctrl_q.mode == MODE_WDOG);
    is_os    = (ctrl_q.mode == MODE_ONESHOT);
    is_per   = !is_wd && !is_os;
    wr_ctrl  = wr_i && (reg_i == REG_CTRL);
    start    = wr_ctrl && ctrl_new.en && !ctrl_q.en;
    svc      = wr_i && (reg_i == REG_SVC) && (wdata_i == KEY) && ctrl_q.en && is_wd;
    expire   = tick && (cnt_q == '0) && !svc;
    reload   = start || svc || (expire && is_per);
    clr      = wr_i && (reg_i == REG_STAT) && wdata_i[0];
  end

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (ctrl_q.en),
    .load_i     (reload),
    .load_val_i (ps_q),
    .div_i      (act_ps_q),
    .tick_o     (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      rl_q     <= '0;
      ps_q     <= '0;
      act_ps_q <= '0;
      cnt_q    <= '0;
      pend_q   <= 1'b0;
      bite_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_new;
      if (expire && !is_per) ctrl_q.en <= 1'b0;
      if (wr_i && (reg_i == REG_RELOAD)) rl_q <= wdata_i[CNT_W-1:0];
      if (wr_i && (reg_i == REG_PRESC))  ps_q <= wdata_i[PRE_W-1:0];
      if (reload) begin
        cnt_q    <= rl_q;
        act_ps_q <= ps_q;
      end else if (tick && (cnt_q != '0)) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (expire)   pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
      if (expire && is_wd) bite_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (reg_i)
      REG_CTRL:   rdata_o = DW'(ctrl_q);
      REG_RELOAD: rdata_o = DW'(rl_q);
      REG_PRESC:  rdata_o = DW'(ps_q);
      REG_COUNT:  rdata_o = DW'(cnt_q);
      REG_STAT:   rdata_o = DW'({bite_q, ctrl_q.en, pend_q});
      default:    rdata_o = '0;
    endcase
  end

  assign count_o = cnt_q;
  assign pend_o  = pend_q;
  assign run_o   = ctrl_q.en;
  assign irq_o   = pend_q && ctrl_q.ie;
  assign bite_o  = bite_q;
endmodule

// File: rtl/duo_timer.sv
module duo_timer
  import tmr_pkg::*;
#(
  parameter int          NCH   = 2,
  parameter int          CNT_W = 32,
  parameter int          PRE_W = 32,
  parameter logic [31:0] KEY   = 32'hC0DE_5A5A,
  localparam int         CW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int         AW    = CW + 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NCH-1:0] irq_o,
  output logic           wdog_rst_o
);
  logic [CW-1:0]             ch_idx;
  reg_e                      reg_sel;
  logic [DW-1:0]             ch_rd [NCH];
  logic [NCH-1:0]            pend_w, run_w, bite_w;
  logic [NCH-1:0][CNT_W-1:0] cnt_w;

  assign ch_idx  = addr_i[AW-1:3];
  assign reg_sel = reg_e'(addr_i[2:0]);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W), .KEY(KEY)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en_i && (ch_idx == CW'(c))),
      .reg_i   (reg_sel),
      .wdata_i (wdata_i),
      .rdata_o (ch_rd[c]),
      .count_o (cnt_w[c]),
      .pend_o  (pend_w[c]),
      .run_o   (run_w[c]),
      .irq_o   (irq_o[c]),
      .bite_o  (bite_w[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_idx == CW'(c)) rdata_o = ch_rd[c];
    end
  end

  assign wdog_rst_o = |bite_w;
endmodule

// File: rtl/duo_timer_chk.sv
module duo_timer_chk #(
  parameter int NCH   = 2,
  parameter int CNT_W = 32,
  parameter int AW    = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      wr_en_i,
  input logic [AW-1:0]             addr_i,
  input logic                      wbit0_i,
  input logic                      wdog_rst_o,
  input logic [NCH-1:0]            pend_w,
  input logic [NCH-1:0]            run_w,
  input logic [NCH-1:0][CNT_W-1:0] cnt_w
);
  localparam int CW = AW - 3;

  // R6
  wdog_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_o |=> wdog_rst_o);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    logic wr_c, clr_c, ctrl_c;
    assign wr_c   = wr_en_i && (addr_i[AW-1:3] == CW'(c));
    assign clr_c  = wr_c && (addr_i[2:0] == 3'd4) && wbit0_i;
    assign ctrl_c = wr_c && (addr_i[2:0] == 3'd0);

    // R7
    pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_w[c] && !clr_c |=> pend_w[c]);

    // R5
    self_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_w[c] && !ctrl_c |=> run_w[c] || pend_w[c]);

    // R3
    count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_w[c] && !wr_c |=> (cnt_w[c] == $past(cnt_w[c])) ||
                            (cnt_w[c] == $past(cnt_w[c]) - CNT_W'(1)) ||
                            ($past(cnt_w[c]) == '0));

    // R10
    count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_w[c] && !wr_c |=> $stable(cnt_w[c]));
  end
endmodule

bind duo_timer duo_timer_chk #(.NCH(NCH), .CNT_W(CNT_W), .AW(AW)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wbit0_i    (wdata_i[0]),
  .wdog_rst_o (wdog_rst_o),
  .pend_w     (pend_w),
  .run_w      (run_w),
  .cnt_w      (cnt_w)
);

// File: tb/duo_timer_tb_top.sv
module duo_timer_tb_top;
  localparam int NCH = 2;
  localparam int AW  = 4;
  localparam logic [31:0] KEY = 32'hC0DE_5A5A;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           wr_en;
  logic [AW-1:0]  addr;
  logic [31:0]    wdata;
  logic [31:0]    rdata;
  logic [NCH-1:0] irq;
  logic           wdog;

  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;

  duo_timer dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .irq_o      (irq),
    .wdog_rst_o (wdog)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int ch, input int rg, input logic [31:0] v);
    addr  = AW'(ch * 8 + rg);
    wdata = v;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int rg, output logic [31:0] v);
    addr = AW'(ch * 8 + rg);
    #1;
    v = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] exp_count(int r, int p, int m, bit oneshot);
    int j = m / (p + 1);
    if (oneshot) return (j >= r) ? 32'd0 : 32'(r - j);
    return 32'(r - (j % (r + 1)));
  endfunction

  function automatic bit exp_expired(int r, int p, int m);
    return m >= (r + 1) * (p + 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    addr = '0; wdata = '0;
    do_reset();

    // R1 reset state
    for (int c = 0; c < NCH; c++) begin
      for (int r = 0; r < 5; r++) begin
        rd(c, r, v); check("R1", "register after reset", v, 32'd0);
      end
    end
    check("R1", "irq after reset", 32'(irq), 32'd0);
    check("R1", "wdog after reset", 32'(wdog), 32'd0);

    // R2 readback
    wr(1, 1, 32'hDEAD_BEEF); rd(1, 1, v); check("R2", "reload readback", v, 32'hDEAD_BEEF);
    wr(1, 2, 32'h0000_1234); rd(1, 2, v); check("R2", "prescale readback", v, 32'h1234);
    wr(1, 0, 32'hC);         rd(1, 0, v); check("R2", "ctrl readback", v, 32'hC);
    rd(0, 1, v); check("R9", "other channel untouched", v, 32'd0);

    // R8 prescale and reload take effect at next reload
    do_reset();
    wr(0, 1, 3); wr(0, 2, 0);
    wr(0, 0, 32'h1);                     // start at edge k
    wr(0, 2, 2);                         // edge k+1
    rd(0, 3, v); check("R8", "count after prescale write", v, 2);
    step(3); rd(0, 3, v); check("R4", "periodic reload", v, 3);
    step(2); rd(0, 3, v); check("R8", "new prescale slows ticks", v, 3);
    step(1); rd(0, 3, v); check("R8", "tick at new rate", v, 2);
    wr(0, 1, 7);                         // edge k+8
    rd(0, 3, v); check("R8", "reload write not immediate", v, 2);
    step(8); rd(0, 3, v); check("R8", "new reload at expiry", v, 7);
    rd(0, 4, v); check("R4", "pending after periodic expiry", v & 32'h3, 32'h3);

    // R10 disable freezes, enable restarts
    do_reset();
    wr(0, 1, 10); wr(0, 0, 32'h1);
    step(3);
    wr(0, 0, 32'h0);                     // edge k+4, last tick
    rd(0, 3, v); check("R10", "count at disable", v, 6);
    step(5); rd(0, 3, v); check("R10", "count frozen", v, 6);
    wr(0, 0, 32'h1); rd(0, 3, v); check("R10", "restart from reload", v, 10);

    // R5 one-shot, R7 pending and irq gating
    do_reset();
    wr(0, 1, 2); wr(0, 2, 1);
    wr(0, 0, 32'hB);                     // en, one-shot, ie
    step(5);
    rd(0, 4, v); check("R5", "running before expiry", v, 32'h2);
    rd(0, 3, v); check("R3", "count reached zero", v, 0);
    step(1);
    rd(0, 4, v); check("R5", "pending, stopped after expiry", v, 32'h1);
    check("R7", "irq with ie set", 32'(irq[0]), 1);
    wr(0, 4, 32'h0); rd(0, 4, v); check("R7", "write 0 keeps pending", v, 32'h1);
    wr(0, 0, 32'h2); check("R7", "irq masked by ie", 32'(irq[0]), 0);
    rd(0, 4, v); check("R7", "pending kept while masked", v, 32'h1);
    wr(0, 4, 32'h1); step(20);
    rd(0, 4, v); check("R5", "no second expiry", v, 32'h0);
    rd(0, 3, v); check("R5", "count stays zero", v, 0);

    // R7 set wins over clear
    do_reset();
    wr(0, 0, 32'h1); step(2);
    wr(0, 4, 32'h1); rd(0, 4, v); check("R7", "set wins over clear", v & 32'h1, 1);
    wr(0, 0, 32'h0); wr(0, 4, 32'h1); rd(0, 4, v); check("R7", "clear when idle", v, 0);

    // R6 watchdog on channel 1
    do_reset();
    wr(1, 1, 5); wr(1, 0, 32'h5);
    step(3);
    wr(1, 5, KEY); rd(1, 3, v); check("R6", "service reloads", v, 5);
    step(2);
    wr(1, 5, 32'h1234_5678); rd(1, 3, v); check("R6", "wrong key ignored", v, 2);
    check("R6", "no request before expiry", 32'(wdog), 0);
    step(2); check("R6", "no request at zero", 32'(wdog), 0);
    step(1); check("R6", "request on expiry", 32'(wdog), 1);
    rd(1, 4, v); check("R6", "status after bite", v, 32'h5);
    wr(1, 4, 32'h1); rd(1, 4, v); check("R6", "bite bit after clear", v, 32'h4);
    check("R6", "request sticky", 32'(wdog), 1);
    check("R9", "channel 0 irq quiet", 32'(irq[0]), 0);
    do_reset(); check("R6", "request cleared by reset", 32'(wdog), 0);

    // R3 R4 R5 R9 random runs on both channels
    for (int it = 0; it < 30; it++) begin
      int  r0 = $urandom_range(15), p0 = $urandom_range(3);
      int  r1 = $urandom_range(15), p1 = $urandom_range(3);
      int  m  = $urandom_range(80);
      bit  os1 = 1'($urandom_range(1));
      bit  e0, e1;
      wr(0, 0, 0); wr(1, 0, 0); wr(0, 4, 1); wr(1, 4, 1);
      wr(0, 1, 32'(r0)); wr(0, 2, 32'(p0));
      wr(1, 1, 32'(r1)); wr(1, 2, 32'(p1));
      wr(0, 0, 32'h9);
      wr(1, 0, os1 ? 32'hB : 32'h9);
      step(m);
      e0 = exp_expired(r0, p0, m + 1);
      e1 = exp_expired(r1, p1, m);
      rd(0, 3, v); check("R3", "random count ch0", v, exp_count(r0, p0, m + 1, 1'b0));
      rd(1, 3, v); check("R9", "random count ch1", v, exp_count(r1, p1, m, os1));
      rd(0, 4, v); check("R4", "random status ch0", v, {30'd0, 1'b1, e0});
      rd(1, 4, v); check("R5", "random status ch1", v, {30'd0, !(os1 && e1), e1});
      check("R7", "random irq", 32'(irq), {30'd0, e1, e0});
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule